// File: doc/BRIEF.md
# Host Configuration Access Port

This block gives a host processor access to a small configuration space for each of a fixed set of devices. It does this through two 32-bit I/O ports, and software reaches each port one byte at a time. The selector port collects a 32-bit selection word byte by byte. That word picks a bus, a device, a function and a dword register. The window port then returns the selected dword, or accepts byte writes into it.

The result for the window port is captured once, when the top byte of the selector is written. At that same moment a presence flag is captured, and it can be read back through the selector port. Each device holds 64 bytes of configuration storage as 16 little-endian dwords. The storage is loaded from a parameter at reset. Dwords 4 to 9 are base address registers. Each one is either absent or has a power-of-two size. When the top byte of such a dword is written, the stored value is masked to its size, with the low two bits forced to 1. An absent register is cleared to zero instead.

Device presence, device addresses, base address register sizes, port locations and initial contents are all set through parameters.

Top module: `cfg_access_port`

## Requirements
- R1: A byte write to selector lane N (port base + N, N = 0..3) replaces bits 8N+7:8N of the selection word and leaves the other bytes unchanged.
- R2: Only a write to selector lane 3 refreshes the presence flag and the window result. Writes to lanes 0..2 leave both of them unchanged.
- R3: The selector port reads 0x80000000 after a selection whose bits 23:8 (bus 23:16, device 15:11, function 10:8) match a configured device. Otherwise it reads 0. Bit 31 of the selection word does not affect the match.
- R4: The window result is the dword at register index bits 7:2 of the matched device. Bits 1:0 are ignored. It is 0 when no device matches or when the index is 16 or more. Byte writes to an index of 16 or more change nothing.
- R5: A byte written to window lane N is stored as byte N of the selected dword. Dwords are little-endian, so lane 0 holds bits 7:0.
- R6: Window writes while no device matches change no device's storage.
- R7: A lane-3 write to dword index 4..9 (byte offsets 0x10..0x27) of a device whose base address register (index − 4) has size 2^k stores (value AND NOT (2^k − 1)) OR 3. Dwords outside that range are stored unmodified.
- R8: A lane-3 write to a base address register that is absent (size code 0) stores 0.
- R9: Writes to lanes 0..2 of a base address register are stored raw, with no masking.
- R10: A window write does not alter the window result until the next selector lane-3 write.
- R11: After reset the selection word, presence flag and window result are 0, and each device's storage holds its initial parameter contents.
- R12: Read data is 0 when the read strobe is low, or when the port address hits neither the selector nor the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | IO_AW | Byte port address |
| io_wr_i | input | 1 | Write strobe, one byte per cycle |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write byte |
| io_rdata_o | output | 8 | Read byte, combinational from registered state |

## Verification
The bench builds the block with three devices. Two sit on bus 0 at device numbers 0 and 1. The third sits on bus 1, device 2, so a match that depends on the bus byte is exercised and not only the device and function fields. The second device has base address registers of 16 bytes and 4 KiB, and the others absent. The third device has a 256-byte register in the last slot. Together these cover both sizes of mask, the absent-register clear, and both edges of the base address window. The third device's last dword is non-zero, so the top in-range index is read back as a distinct value.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DW_PER_DEV   = 16;
  localparam int IDX_W        = 6;
  localparam int BAR_NUM      = 6;
  localparam int BAR_BASE_IDX = 4;
  localparam int LOG2_W       = 5;

  typedef logic [31:0] dword_t;

  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] reg_idx;
    logic [1:0] low;
  } cfg_sel_t;

  // size code 0 = register absent, else size = 2**code
  function automatic dword_t bar_fix(dword_t v, logic [LOG2_W-1:0] code);
    dword_t mask;
    if (code == '0) return '0;
    mask = ~((dword_t'(1) << code) - dword_t'(1));
    return (v & mask) | dword_t'(3);
  endfunction
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] lane_i,
  input  logic [7:0] wdata_i,
  output dword_t     addr_o,
  output dword_t     addr_nxt_o,
  output logic       fire_o
);
  dword_t addr_q;

  always_comb begin
    addr_nxt_o = addr_q;
    if (wr_i) addr_nxt_o[{lane_i, 3'b000} +: 8] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (wr_i) addr_q <= addr_nxt_o;
  end

  assign addr_o = addr_q;
  assign fire_o = wr_i && (lane_i == 2'd3);
endmodule

// File: rtl/cfg_dev_space.sv
module cfg_dev_space
  import cfg_port_pkg::*;
#(
  parameter logic [DW_PER_DEV-1:0][31:0]    INIT     = '0,
  parameter logic [BAR_NUM-1:0][LOG2_W-1:0] BAR_LOG2 = '0
)(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [1:0]                   lane_i,
  input  logic [7:0]                   wdata_i,
  output logic [DW_PER_DEV-1:0][31:0]  words_o
);
  localparam int WIDX_W = $clog2(DW_PER_DEV);

  logic   in_range;
  dword_t merged;

  assign in_range = (idx_i < IDX_W'(DW_PER_DEV));

  always_comb begin
    merged = words_o[idx_i[WIDX_W-1:0]];
    merged[{lane_i, 3'b000} +: 8] = wdata_i;
  end

  for (genvar g = 0; g < DW_PER_DEV; g++) begin : g_word
    dword_t word_q, word_d;
    logic   we;

    assign we = wr_i && in_range && (idx_i[WIDX_W-1:0] == WIDX_W'(g));

    if (g >= BAR_BASE_IDX && g < BAR_BASE_IDX + BAR_NUM) begin : g_bar
      // size mask applies only once the top byte lands
      assign word_d = (lane_i == 2'd3) ? bar_fix(merged, BAR_LOG2[g-BAR_BASE_IDX]) : merged;
    end else begin : g_plain
      assign word_d = merged;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= INIT[g];
      else if (we)  word_q <= word_d;
    end

    assign words_o[g] = word_q;
  end
endmodule

// File: rtl/cfg_lookup.sv
module cfg_lookup
  import cfg_port_pkg::*;
#(
  parameter int                     N_DEV   = 2,
  parameter logic [N_DEV-1:0][15:0] DEV_BDF = {16'h0008, 16'h0000}
)(
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   fire_i,
  input  cfg_sel_t                               sel_i,
  input  logic [N_DEV-1:0][DW_PER_DEV-1:0][31:0] words_i,
  output logic                                   hit_o,
  output dword_t                                 resp_o
);
  localparam int SEL_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int WIDX_W = $clog2(DW_PER_DEV);

  logic             hit_d, hit_q;
  logic [SEL_W-1:0] pick;
  dword_t           resp_d, resp_q;

  always_comb begin
    hit_d = 1'b0;
    pick  = '0;
    // descending scan: lowest matching slot wins
    for (int d = N_DEV - 1; d >= 0; d--) begin
      if ({sel_i.bus, sel_i.dev, sel_i.fn} == DEV_BDF[d]) begin
        hit_d = 1'b1;
        pick  = SEL_W'(d);
      end
    end
    resp_d = '0;
    if (hit_d && (sel_i.reg_idx < IDX_W'(DW_PER_DEV)))
      resp_d = words_i[pick][sel_i.reg_idx[WIDX_W-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      resp_q <= '0;
    end else if (fire_i) begin
      hit_q  <= hit_d;
      resp_q <= resp_d;
    end
  end

  assign hit_o  = hit_q;
  assign resp_o = resp_q;
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_port_pkg::*;
#(
  parameter int                   N_DEV     = 2,
  parameter int                   IO_AW     = 16,
  parameter logic [IO_AW-1:0]     ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0]     DATA_PORT = 16'h0CFC,
  parameter logic [N_DEV-1:0][15:0] DEV_BDF = {16'h0008, 16'h0000},
  parameter logic [N_DEV-1:0][BAR_NUM-1:0][LOG2_W-1:0] DEV_BAR_LOG2 = '0,
  parameter logic [N_DEV-1:0][DW_PER_DEV-1:0][31:0] DEV_INIT = {
    {12{32'h0}}, 32'h0080_0000, 32'h0601_0000, 32'h0200_0007, 32'h7000_8086,
    {13{32'h0}}, 32'h0600_0002, 32'h0000_0000, 32'h1237_8086}
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_wr_i,
  input  logic             io_rd_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o
);
  logic       ap_sel, dp_sel, fire, hit_q;
  logic [1:0] lane;
  dword_t     addr_q, addr_nxt, resp_q, status;
  cfg_sel_t   cur_sel, nxt_sel;
  logic [N_DEV-1:0][DW_PER_DEV-1:0][31:0] dev_words;

  assign ap_sel = (io_addr_i[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
  assign dp_sel = (io_addr_i[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
  assign lane   = io_addr_i[1:0];

  cfg_addr_latch u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (io_wr_i && ap_sel),
    .lane_i     (lane),
    .wdata_i    (io_wdata_i),
    .addr_o     (addr_q),
    .addr_nxt_o (addr_nxt),
    .fire_o     (fire)
  );

  assign cur_sel = cfg_sel_t'(addr_q);
  assign nxt_sel = cfg_sel_t'(addr_nxt);

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic dev_we;
    assign dev_we = io_wr_i && dp_sel &&
                    ({cur_sel.bus, cur_sel.dev, cur_sel.fn} == DEV_BDF[d]);

    cfg_dev_space #(
      .INIT     (DEV_INIT[d]),
      .BAR_LOG2 (DEV_BAR_LOG2[d])
    ) u_space (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (dev_we),
      .idx_i   (cur_sel.reg_idx),
      .lane_i  (lane),
      .wdata_i (io_wdata_i),
      .words_o (dev_words[d])
    );
  end

  cfg_lookup #(
    .N_DEV   (N_DEV),
    .DEV_BDF (DEV_BDF)
  ) u_look (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .sel_i   (nxt_sel),
    .words_i (dev_words),
    .hit_o   (hit_q),
    .resp_o  (resp_q)
  );

  assign status = {hit_q, 31'b0};

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      if (ap_sel)      io_rdata_o = status[{lane, 3'b000} +: 8];
      else if (dp_sel) io_rdata_o = resp_q[{lane, 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/cfg_access_port_chk.sv
module cfg_access_port_chk
  import cfg_port_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8
)(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IO_AW-1:0] io_addr_i,
  input logic             io_wr_i,
  input logic             io_rd_i,
  input logic [7:0]       io_wdata_i,
  input logic [7:0]       io_rdata_o,
  input dword_t           addr_q_i,
  input dword_t           resp_q_i,
  input logic             hit_q_i
);
  localparam logic [IO_AW-1:0] AP_TOP = ADDR_PORT | IO_AW'(3);

  logic ap_hit;
  assign ap_hit = (io_addr_i[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);

  p_latch_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && ap_hit |=> addr_q_i[{$past(io_addr_i[1:0]), 3'b000} +: 8] == $past(io_wdata_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i == AP_TOP) |=> $stable(resp_q_i) && $stable(hit_q_i));

  p_status_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && ap_hit && io_addr_i[1:0] != 2'd3 |-> io_rdata_o == 8'h00);

  p_status_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && io_addr_i == AP_TOP |-> (io_rdata_o == 8'h00 || io_rdata_o == 8'h80));

  p_absent_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_q_i |-> resp_q_i == '0);

  p_idle_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == 8'h00);
endmodule

bind cfg_access_port cfg_access_port_chk #(
  .IO_AW     (IO_AW),
  .ADDR_PORT (ADDR_PORT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .addr_q_i   (addr_q),
  .resp_q_i   (resp_q),
  .hit_q_i    (hit_q)
);

// File: tb/sim_cfg_access_port.sv
`timescale 1ns/1ps
module sim_cfg_access_port;
  localparam logic [15:0] AP = 16'h0CF8;
  localparam logic [15:0] DP = 16'h0CFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfg_access_port #(
    .N_DEV   (3),
    .DEV_BDF ({16'h0110, 16'h0008, 16'h0000}),
    .DEV_BAR_LOG2 ({ {5'd8, 25'd0},
                     {5'd0, 5'd0, 5'd0, 5'd0, 5'd12, 5'd4},
                     30'd0 }),
    .DEV_INIT ({
      32'hA5A5_005A, {14{32'h0}}, 32'hBEEF_1234,
      {12{32'h0}}, 32'h0080_0000, 32'h0601_0000, 32'h0200_0007, 32'h7000_8086,
      {13{32'h0}}, 32'h0600_0002, 32'h0000_0000, 32'h1237_8086})
  ) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .io_addr_i  (io_addr),
    .io_wr_i    (io_wr),
    .io_rd_i    (io_rd),
    .io_wdata_i (io_wdata),
    .io_rdata_o (io_rdata)
  );

  typedef struct packed {
    logic [31:0] sel;
    logic [31:0] st;
    logic [31:0] dat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_0000, 32'h8000_0000, 32'h1237_8086},
    '{32'h0000_0008, 32'h8000_0000, 32'h0600_0002},
    '{32'h8000_0800, 32'h8000_0000, 32'h7000_8086},
    '{32'h8000_0804, 32'h8000_0000, 32'h0200_0007},
    '{32'h8000_080B, 32'h8000_0000, 32'h0601_0000},
    '{32'h8000_1000, 32'h0000_0000, 32'h0000_0000},
    '{32'h8001_1000, 32'h8000_0000, 32'hBEEF_1234},
    '{32'h8001_103C, 32'h8000_0000, 32'hA5A5_005A},
    '{32'h8001_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h8000_0840, 32'h8000_0000, 32'h0000_0000},
    '{32'h8000_0901, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic rd32(input logic [15:0] base, output logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      io_read(base + 16'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic sel(input logic [31:0] a);
    for (int i = 0; i < 4; i++) io_write(AP + 16'(i), a[8*i +: 8]);
  endtask

  task automatic wr32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) io_write(DP + 16'(i), v[8*i +: 8]);
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] v;
    sel(a);
    rd32(DP, v);
    check(req, v, exp);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd32(AP, v); check("R11 status after reset", v, 32'h0);
    rd32(DP, v); check("R11 window after reset", v, 32'h0);
    io_write(AP + 16'd3, 8'h80); // latch was zero, so selects device 0 offset 0
    rd32(AP, v); check("R11 latch cleared, status", v, 32'h8000_0000);
    rd32(DP, v); check("R11 initial contents", v, 32'h1237_8086);

    // R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      sel(VECS[i].sel);
      rd32(AP, v); check($sformatf("R3 vec %0d status", i), v, VECS[i].st);
      rd32(DP, v); check($sformatf("R4 vec %0d window", i), v, VECS[i].dat);
    end

    // R1 R2: partial selector writes do not refresh
    sel(32'h8000_0800);
    io_write(AP + 16'd0, 8'h00);
    io_write(AP + 16'd1, 8'h10);
    io_write(AP + 16'd2, 8'h00);
    rd32(AP, v); check("R2 status held", v, 32'h8000_0000);
    rd32(DP, v); check("R2 window held", v, 32'h7000_8086);
    io_write(AP + 16'd3, 8'h80);
    rd32(AP, v); check("R1 assembled absent select", v, 32'h0);
    io_write(AP + 16'd1, 8'h08);
    io_write(AP + 16'd0, 8'h04);
    io_write(AP + 16'd3, 8'h00);
    rd32(DP, v); check("R1 byte-wise reassembly", v, 32'h0200_0007);

    // R10 R5: window write is not visible until next lookup
    sel(32'h8001_1030);
    wr32(32'h4433_2211);
    rd32(DP, v); check("R10 stale window", v, 32'h0);
    look("R5 lanes little-endian", 32'h8001_1030, 32'h4433_2211);
    io_write(DP + 16'd2, 8'h99);
    look("R5 single lane", 32'h8001_1030, 32'h4499_2211);

    // R9 R7: BAR lanes and masking
    sel(32'h8000_0810);
    io_write(DP + 16'd0, 8'hFF);
    io_write(DP + 16'd1, 8'hFF);
    io_write(DP + 16'd2, 8'hFF);
    look("R9 low lanes raw", 32'h8000_0810, 32'h00FF_FFFF);
    io_write(DP + 16'd3, 8'hAB);
    look("R7 16-byte bar", 32'h8000_0810, 32'hABFF_FFF3);
    wr32(32'hFFFF_FFFF);
    look("R7 4KiB bar", 32'h8000_0814, 32'h0);
    sel(32'h8000_0814);
    wr32(32'hFFFF_FFFF);
    look("R7 4KiB bar", 32'h8000_0814, 32'hFFFF_F003);
    sel(32'h8001_1024);
    wr32(32'hFFFF_FFFF);
    look("R7 last bar slot", 32'h8001_1024, 32'hFFFF_FF03);
    sel(32'h8001_1028);
    wr32(32'hFFFF_FFFF);
    look("R7 above window raw", 32'h8001_1028, 32'hFFFF_FFFF);
    sel(32'h8000_080C);
    wr32(32'h1234_5678);
    look("R7 below window raw", 32'h8000_080C, 32'h1234_5678);

    // R8: absent BAR clears
    sel(32'h8000_0818);
    wr32(32'h1212_1212);
    look("R8 absent bar", 32'h8000_0818, 32'h0);

    // R6 R4: dropped writes
    sel(32'h8000_1000);
    wr32(32'hEFBE_ADDE);
    look("R6 dev0 untouched", 32'h8000_0000, 32'h1237_8086);
    sel(32'h8000_0840);
    wr32(32'hEFBE_ADDE);
    look("R4 out-of-range write ignored", 32'h8000_0800, 32'h7000_8086);
    look("R6 dev2 untouched", 32'h8001_1000, 32'hBEEF_1234);

    // R12: idle strobe and unmapped ports
    @(negedge clk);
    io_addr = DP; io_rd = 1'b0;
    #1 check("R12 strobe low", {24'h0, io_rdata}, 32'h0);
    io_read(16'h0CF7, b); check("R12 unmapped below", {24'h0, b}, 32'h0);
    io_read(16'h0D00, b); check("R12 unmapped above", {24'h0, b}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule